// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block gathers 32 interrupt lines and presents them to a processor as two request outputs. Each line is synchronised to the block clock. It is then turned into an "active" indication according to its own trigger mode: rising edge, falling edge, active-high level, active-low level, or off. Edge events are held in sticky capture flops until software clears them. Level lines follow the input directly, with no latching.

An active line reaches a request output only when its source-enable bit and its mask bit are both 1. A per-line routing bit chooses which of the two outputs the line feeds. Software sees two read-only pending vectors, one for each output, and each request output is high whenever its pending vector is non-zero.

All control state is kept in set/clear register pairs on a small word-addressed register bus. Software can therefore change single bits with one write and no read-modify-write. Read data is registered and appears one clock after the address is presented. Reset is synchronous and active-high.

Top module: `irq_route_ctl`

## Requirements
- R1: The trigger code of source n is {plane2[n], plane1[n], plane0[n]}: 001 is rising edge, 010 is falling edge, 101 is active-high level, 110 is active-low level, and 000 is off; an off source never shows pending.
- R2: The unused codes 011, 100 and 111 behave as off: the source never shows pending, whatever its input does.
- R3: Address map (4-bit word address): 0/1 plane0 set/clear, 2/3 plane1 set/clear, 4/5 plane2 set/clear, 6/7 routing set/clear, 8/9 enable set/clear, 10/11 mask set/clear, 12 rising-capture clear, 13 falling-capture clear, 14 pending for request 0, 15 pending for request 1. A write to a set or clear address changes only the bits written as 1. A read of either address of a pair returns that register. A read of 12 or 13 returns the rising or falling capture vector. Read data is valid one clock after the address.
- R4: A source whose routing bit is 1 shows in the pending vector of request 0 (address 14). A source whose routing bit is 0 shows in the pending vector of request 1 (address 15). A source never shows in both.
- R5: A source shows pending only while its mask bit is 1. An edge captured while the mask is 0 is kept and shows as soon as the mask is set.
- R6: A source shows pending only while its source-enable bit is 1.
- R7: Edge captures are sticky. A rising capture is cleared only by writing 1 at its bit to address 12, and a falling capture only by writing 1 to address 13. The other clear address does not affect it. A detected edge in the same cycle as the clear wins.
- R8: A level-mode source follows its synchronised input, or its inverse in low-level mode, and drops from pending as soon as the input becomes inactive.
- R9: Request output 0 is high exactly when pending vector 0 is non-zero, and request output 1 is high exactly when pending vector 1 is non-zero.
- R10: Reset clears all configuration, routing, enable, mask and capture state, both pending vectors and both request outputs.
- R11: Suppose a level-mode input becomes active before clock edge k and the source is already enabled, unmasked and routed. Its request output stays low after edge k+1 and is high after edge k+2, because of the two synchroniser stages and the registered output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data, one bit per source |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 32 | Raw asynchronous interrupt lines |
| req0 | output | 1 | Request output 0 |
| req1 | output | 1 | Request output 1 |

## Verification
The bench drives each trigger code, including the three unused ones. A decoder that treated a bit pattern loosely would show a level or edge source as pending where none should appear. An edge is captured while the source is masked and then unmasked, and it is also cleared through the wrong clear address; a design that gated capture with the mask, or shared one clear for both edges, would lose or drop the event. Routing is moved between the two outputs and two sources are active at once, which exposes swapped routing polarity or a request output that is not the OR of its vector. The exact cycle in which a level input reaches the request output is checked against the two-stage synchroniser depth.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int REG_AW = 4;
  localparam int N_CTL  = 6;  // plane0, plane1, plane2, routing, enable, mask

  // Control register index in the set/clear bank (address = 2*index + clear)
  localparam int CTL_PLANE0 = 0;
  localparam int CTL_PLANE1 = 1;
  localparam int CTL_PLANE2 = 2;
  localparam int CTL_ROUTE  = 3;
  localparam int CTL_ENABLE = 4;
  localparam int CTL_MASK   = 5;

  localparam logic [REG_AW-1:0] ADR_RCAP_CLR = 4'd12;
  localparam logic [REG_AW-1:0] ADR_FCAP_CLR = 4'd13;
  localparam logic [REG_AW-1:0] ADR_PEND0    = 4'd14;
  localparam logic [REG_AW-1:0] ADR_PEND1    = 4'd15;

  typedef enum logic [2:0] {
    TK_OFF,
    TK_RISE,
    TK_FALL,
    TK_HIGH,
    TK_LOW
  } trig_kind_e;

  function automatic trig_kind_e decode_trig(input logic [2:0] code);
    case (code)
      3'b001:  return TK_RISE;
      3'b010:  return TK_FALL;
      3'b101:  return TK_HIGH;
      3'b110:  return TK_LOW;
      default: return TK_OFF;  // 000 and the unused patterns
    endcase
  endfunction

endpackage

// File: rtl/irq_in_sync.sv
// Two-stage synchroniser plus one history stage for edge detection.
module irq_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      meta_q <= raw;
      cur    <= meta_q;
      prev   <= cur;
    end
  end

endmodule

// File: rtl/irq_w1sc_reg.sv
// Register with separate write-one-to-set and write-one-to-clear strobes.
module irq_w1sc_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (set_stb) begin
      q <= q | wdata;
    end else if (clr_stb) begin
      q <= q & ~wdata;
    end
  end

endmodule

// File: rtl/irq_src_slice.sv
// Per-source trigger evaluation and sticky edge capture.
module irq_src_slice
  import irq_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] code,
  input  logic       cur,
  input  logic       prev,
  input  logic       rise_clr,
  input  logic       fall_clr,
  output logic       active,
  output logic       rise_cap,
  output logic       fall_cap
);

  trig_kind_e kind;
  logic       rise_seen;
  logic       fall_seen;

  always_comb begin
    kind      = decode_trig(code);
    rise_seen = (kind == TK_RISE) && cur && !prev;
    fall_seen = (kind == TK_FALL) && !cur && prev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_cap <= 1'b0;
      fall_cap <= 1'b0;
    end else begin
      rise_cap <= (rise_cap && !rise_clr) || rise_seen;
      fall_cap <= (fall_cap && !fall_clr) || fall_seen;
    end
  end

  always_comb begin
    case (kind)
      TK_RISE: active = rise_cap;
      TK_FALL: active = fall_cap;
      TK_HIGH: active = cur;
      TK_LOW:  active = !cur;
      default: active = 1'b0;
    endcase
  end

endmodule

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
  import irq_route_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [N_SRC-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  irq_in,
  output logic              req0,
  output logic              req1
);

  localparam int IDX_W = REG_AW - 1;

  logic [N_CTL-1:0][N_SRC-1:0] ctl_q;
  logic [N_SRC-1:0] cfg0_q, cfg1_q, cfg2_q, route_q, en_q, mask_q;
  logic [N_SRC-1:0] sync_cur, sync_prev;
  logic [N_SRC-1:0] active, rise_cap, fall_cap;
  logic [N_SRC-1:0] contrib, pend0_next, pend1_next;
  logic [N_SRC-1:0] pend0_q, pend1_q;
  logic             rclr_stb, fclr_stb;

  // Set/clear control bank
  for (genvar k = 0; k < N_CTL; k++) begin : g_ctl
    localparam logic [REG_AW-1:0] A_SET = REG_AW'(2 * k);
    localparam logic [REG_AW-1:0] A_CLR = REG_AW'(2 * k + 1);
    irq_w1sc_reg #(.W(N_SRC)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .set_stb (bus_we && (bus_addr == A_SET)),
      .clr_stb (bus_we && (bus_addr == A_CLR)),
      .wdata   (bus_wdata),
      .q       (ctl_q[k])
    );
  end

  assign cfg0_q  = ctl_q[CTL_PLANE0];
  assign cfg1_q  = ctl_q[CTL_PLANE1];
  assign cfg2_q  = ctl_q[CTL_PLANE2];
  assign route_q = ctl_q[CTL_ROUTE];
  assign en_q    = ctl_q[CTL_ENABLE];
  assign mask_q  = ctl_q[CTL_MASK];

  assign rclr_stb = bus_we && (bus_addr == ADR_RCAP_CLR);
  assign fclr_stb = bus_we && (bus_addr == ADR_FCAP_CLR);

  irq_in_sync #(.W(N_SRC)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .raw  (irq_in),
    .cur  (sync_cur),
    .prev (sync_prev)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    irq_src_slice u_slice (
      .clk      (clk),
      .rst      (rst),
      .code     ({cfg2_q[i], cfg1_q[i], cfg0_q[i]}),
      .cur      (sync_cur[i]),
      .prev     (sync_prev[i]),
      .rise_clr (rclr_stb && bus_wdata[i]),
      .fall_clr (fclr_stb && bus_wdata[i]),
      .active   (active[i]),
      .rise_cap (rise_cap[i]),
      .fall_cap (fall_cap[i])
    );
  end

  // Gating and routing
  always_comb begin
    contrib    = active & en_q & mask_q;
    pend0_next = contrib & route_q;
    pend1_next = contrib & ~route_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend0_q <= '0;
      pend1_q <= '0;
      req0    <= 1'b0;
      req1    <= 1'b0;
    end else begin
      pend0_q <= pend0_next;
      pend1_q <= pend1_next;
      req0    <= |pend0_next;
      req1    <= |pend1_next;
    end
  end

  // Registered read port
  logic [IDX_W-1:0] rd_idx;
  logic [N_SRC-1:0] rd_next;

  assign rd_idx = bus_addr[REG_AW-1:1];

  always_comb begin
    case (bus_addr)
      ADR_RCAP_CLR: rd_next = rise_cap;
      ADR_FCAP_CLR: rd_next = fall_cap;
      ADR_PEND0:    rd_next = pend0_q;
      ADR_PEND1:    rd_next = pend1_q;
      default: begin
        if (int'(rd_idx) < N_CTL) rd_next = ctl_q[rd_idx];
        else                      rd_next = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

endmodule

// File: rtl/irq_route_ctl_chk.sv
module irq_route_ctl_chk
  import irq_route_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              we,
  input logic [REG_AW-1:0] addr,
  input logic [N_SRC-1:0]  wdata,
  input logic [N_SRC-1:0]  cfg0,
  input logic [N_SRC-1:0]  cfg1,
  input logic [N_SRC-1:0]  cfg2,
  input logic [N_SRC-1:0]  en,
  input logic [N_SRC-1:0]  mask,
  input logic [N_SRC-1:0]  rcap,
  input logic [N_SRC-1:0]  pend0,
  input logic [N_SRC-1:0]  pend1,
  input logic              req0,
  input logic              req1
);

  logic [N_SRC-1:0] unused_code;
  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      unused_code[i] = ({cfg2[i], cfg1[i], cfg0[i]} == 3'b011) ||
                       ({cfg2[i], cfg1[i], cfg0[i]} == 3'b100) ||
                       ({cfg2[i], cfg1[i], cfg0[i]} == 3'b111);
    end
  end

  a_r2_unused_never_pending: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pend0 | pend1) & $past(unused_code)) == '0));

  a_r3_mask_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 4'd11) |=> ((mask & $past(wdata)) == '0));

  a_r3_enable_set_takes: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 4'd8) |=> ((en & $past(wdata)) == $past(wdata)));

  a_r4_routes_disjoint: assert property (@(posedge clk) disable iff (rst)
    (pend0 & pend1) == '0);

  a_r5_masked_never_pending: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pend0 | pend1) & ~$past(mask)) == '0));

  a_r6_disabled_never_pending: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pend0 | pend1) & ~$past(en)) == '0));

  a_r7_rise_capture_sticky: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == 4'd12) |=> ((rcap & $past(rcap)) == $past(rcap)));

  a_r9_req0_is_or: assert property (@(posedge clk) disable iff (rst)
    req0 == (|pend0));

  a_r9_req1_is_or: assert property (@(posedge clk) disable iff (rst)
    req1 == (|pend1));

endmodule

bind irq_route_ctl irq_route_ctl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .we    (bus_we),
  .addr  (bus_addr),
  .wdata (bus_wdata),
  .cfg0  (cfg0_q),
  .cfg1  (cfg1_q),
  .cfg2  (cfg2_q),
  .en    (en_q),
  .mask  (mask_q),
  .rcap  (rise_cap),
  .pend0 (pend0_q),
  .pend1 (pend1_q),
  .req0  (req0),
  .req1  (req1)
);

// File: tb/irq_route_ctl_test.sv
module irq_route_ctl_test;

  localparam logic [3:0] A_P0S = 4'd0,  A_P0C = 4'd1;
  localparam logic [3:0] A_P1S = 4'd2,  A_P1C = 4'd3;
  localparam logic [3:0] A_P2S = 4'd4,  A_P2C = 4'd5;
  localparam logic [3:0] A_RTS = 4'd6,  A_RTC = 4'd7;
  localparam logic [3:0] A_ENS = 4'd8,  A_ENC = 4'd9;
  localparam logic [3:0] A_MKS = 4'd10, A_MKC = 4'd11;
  localparam logic [3:0] A_RCC = 4'd12, A_FCC = 4'd13;
  localparam logic [3:0] A_PD0 = 4'd14, A_PD1 = 4'd15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic        req0, req1;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_route_ctl uut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .req0      (req0),
    .req1      (req1)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input int src, input logic [2:0] code);
    wr(A_P0C, 32'd1 << src);
    wr(A_P1C, 32'd1 << src);
    wr(A_P2C, 32'd1 << src);
    if (code[0]) wr(A_P0S, 32'd1 << src);
    if (code[1]) wr(A_P1S, 32'd1 << src);
    if (code[2]) wr(A_P2S, 32'd1 << src);
  endtask

  task automatic arm(input int src, input bit to_req0);
    if (to_req0) wr(A_RTS, 32'd1 << src);
    else         wr(A_RTC, 32'd1 << src);
    wr(A_ENS, 32'd1 << src);
    wr(A_MKS, 32'd1 << src);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R10", "req0 after reset", {31'd0, req0}, 32'd0);
    chk("R10", "req1 after reset", {31'd0, req1}, 32'd0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk("R10", $sformatf("register %0d after reset", a), v, 32'd0);
    end
  endtask

  task automatic t_setclr;
    logic [31:0] v;
    wr(A_MKS, 32'h8000_00F0);
    rd(A_MKS, v); chk("R3", "mask after set", v, 32'h8000_00F0);
    wr(A_MKS, 32'h0000_0003);
    rd(A_MKC, v); chk("R3", "mask second set via clear addr", v, 32'h8000_00F3);
    wr(A_MKC, 32'h8000_0010);
    rd(A_MKS, v); chk("R3", "mask after clear", v, 32'h0000_00E3);
    wr(A_MKC, 32'h0);
    rd(A_MKS, v); chk("R3", "zero clear leaves mask", v, 32'h0000_00E3);
    wr(A_RTS, 32'h0000_0A00);
    rd(A_RTC, v); chk("R3", "routing readback", v, 32'h0000_0A00);
    wr(A_RTC, 32'hFFFF_FFFF);
    wr(A_MKC, 32'hFFFF_FFFF);
    rd(A_MKS, v); chk("R3", "mask all cleared", v, 32'h0);
  endtask

  task automatic t_level_high;  // source 5, code 101, to request 0
    logic [31:0] v;
    set_mode(5, 3'b101);
    arm(5, 1'b1);
    idle(3);
    chk("R1", "req0 idle before input", {31'd0, req0}, 32'd0);
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11", "req0 after edge k+1", {31'd0, req0}, 32'd0);
    @(negedge clk);
    chk("R11", "req0 after edge k+2", {31'd0, req0}, 32'd1);
    chk("R4", "req1 unaffected", {31'd0, req1}, 32'd0);
    rd(A_PD0, v); chk("R1", "high level pending0", v, 32'h0000_0020);
    rd(A_PD1, v); chk("R4", "high level not in pending1", v, 32'h0);
    @(negedge clk); irq_in[5] = 1'b0;
    idle(4);
    rd(A_PD0, v); chk("R8", "level drops with input", v, 32'h0);
    chk("R8", "req0 drops", {31'd0, req0}, 32'd0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    @(negedge clk); irq_in[5] = 1'b1;
    idle(4);
    rd(A_PD0, v); chk("R6", "enabled level pending", v, 32'h0000_0020);
    wr(A_ENC, 32'h0000_0020);
    idle(3);
    rd(A_PD0, v); chk("R6", "disabled source not pending", v, 32'h0);
    chk("R6", "req0 low when disabled", {31'd0, req0}, 32'd0);
    wr(A_ENS, 32'h0000_0020);
    idle(3);
    rd(A_PD0, v); chk("R6", "re-enabled pending", v, 32'h0000_0020);
    @(negedge clk); irq_in[5] = 1'b0;
    wr(A_ENC, 32'h0000_0020);
    idle(3);
  endtask

  task automatic t_level_low;  // source 9, code 110, to request 1
    logic [31:0] v;
    set_mode(9, 3'b110);
    arm(9, 1'b0);
    idle(4);
    rd(A_PD1, v); chk("R1", "low level pending1", v, 32'h0000_0200);
    chk("R4", "req1 high for route 0", {31'd0, req1}, 32'd1);
    chk("R4", "req0 low for route 0", {31'd0, req0}, 32'd0);
    @(negedge clk); irq_in[9] = 1'b1;
    idle(4);
    rd(A_PD1, v); chk("R8", "low level inactive when input high", v, 32'h0);
    chk("R9", "req1 low with empty pending1", {31'd0, req1}, 32'd0);
    wr(A_ENC, 32'h0000_0200);
  endtask

  task automatic t_rise;  // source 2, code 001, to request 0, mask left 0
    logic [31:0] v;
    set_mode(2, 3'b001);
    wr(A_RTS, 32'h4);
    wr(A_ENS, 32'h4);
    @(negedge clk); irq_in[2] = 1'b1;
    idle(3);
    irq_in[2] = 1'b0;
    idle(4);
    rd(A_RCC, v); chk("R7", "rising capture set", v, 32'h4);
    rd(A_PD0, v); chk("R5", "masked capture not pending", v, 32'h0);
    wr(A_MKS, 32'h4);
    idle(3);
    rd(A_PD0, v); chk("R5", "capture shows after unmask", v, 32'h4);
    idle(5);
    rd(A_PD0, v); chk("R7", "capture sticky with input low", v, 32'h4);
    wr(A_FCC, 32'h4);
    idle(3);
    rd(A_PD0, v); chk("R7", "falling clear leaves rising capture", v, 32'h4);
    wr(A_RCC, 32'h4);
    idle(3);
    rd(A_PD0, v); chk("R7", "rising clear removes capture", v, 32'h0);
    rd(A_RCC, v); chk("R7", "rising capture vector cleared", v, 32'h0);
    wr(A_ENC, 32'h4);
  endtask

  task automatic t_fall;  // source 12, code 010, to request 1
    logic [31:0] v;
    set_mode(12, 3'b010);
    arm(12, 1'b0);
    @(negedge clk); irq_in[12] = 1'b1;
    idle(4);
    rd(A_PD1, v); chk("R1", "falling mode ignores rise", v, 32'h0);
    @(negedge clk); irq_in[12] = 1'b0;
    idle(4);
    rd(A_PD1, v); chk("R1", "falling edge pending1", v, 32'h0000_1000);
    rd(A_FCC, v); chk("R7", "falling capture vector", v, 32'h0000_1000);
    @(negedge clk); irq_in[12] = 1'b1;
    wr(A_RCC, 32'h0000_1000);
    idle(3);
    rd(A_PD1, v); chk("R7", "rising clear leaves falling capture", v, 32'h0000_1000);
    wr(A_FCC, 32'h0000_1000);
    idle(3);
    rd(A_PD1, v); chk("R7", "falling clear removes capture", v, 32'h0);
    wr(A_ENC, 32'h0000_1000);
  endtask

  task automatic t_unused_codes;  // source 20, to request 0, input held high
    logic [31:0] v0, v1;
    logic [2:0] codes [4] = '{3'b011, 3'b100, 3'b111, 3'b000};
    arm(20, 1'b1);
    @(negedge clk); irq_in[20] = 1'b1;
    foreach (codes[j]) begin
      set_mode(20, codes[j]);
      idle(4);
      rd(A_PD0, v0);
      rd(A_PD1, v1);
      chk(codes[j] == 3'b000 ? "R1" : "R2",
          $sformatf("code %03b gives no pending", codes[j]), v0 | v1, 32'h0);
    end
    set_mode(20, 3'b101);
    idle(4);
    rd(A_PD0, v0); chk("R1", "same source live with code 101", v0, 32'h0010_0000);
    @(negedge clk); irq_in[20] = 1'b0;
    wr(A_ENC, 32'h0010_0000);
  endtask

  task automatic t_or;  // sources 5 and 30 on request 1
    logic [31:0] v;
    wr(A_RTC, 32'h0000_0020);
    wr(A_ENS, 32'h0000_0020);
    set_mode(30, 3'b101);
    arm(30, 1'b0);
    @(negedge clk); irq_in[5] = 1'b1; irq_in[30] = 1'b1;
    idle(4);
    rd(A_PD1, v); chk("R9", "two sources in pending1", v, 32'h4000_0020);
    chk("R9", "req1 high", {31'd0, req1}, 32'd1);
    chk("R9", "req0 low", {31'd0, req0}, 32'd0);
    @(negedge clk); irq_in[5] = 1'b0;
    idle(4);
    rd(A_PD1, v); chk("R9", "one source left", v, 32'h4000_0000);
    chk("R9", "req1 still high", {31'd0, req1}, 32'd1);
    @(negedge clk); irq_in[30] = 1'b0;
    idle(4);
    chk("R9", "req1 low when empty", {31'd0, req1}, 32'd0);
  endtask

  task automatic t_reset_again;
    logic [31:0] v;
    @(negedge clk); irq_in[30] = 1'b1;
    idle(4);
    chk("R10", "req1 high before reset", {31'd0, req1}, 32'd1);
    @(negedge clk); rst = 1'b1;
    idle(2);
    rst = 1'b0;
    chk("R10", "req1 low after reset", {31'd0, req1}, 32'd0);
    rd(A_MKS, v); chk("R10", "mask cleared by reset", v, 32'h0);
    rd(A_P0S, v); chk("R10", "plane0 cleared by reset", v, 32'h0);
    idle(4);
    rd(A_PD1, v); chk("R10", "pending1 stays clear", v, 32'h0);
    irq_in[30] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_setclr();
    t_level_high();
    t_enable();
    t_level_low();
    t_rise();
    t_fall();
    t_unused_codes();
    t_or();
    t_reset_again();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule